// File: doc/BRIEF.md
# Byte Fetch Sequencer

This block times instruction fetch and execution for a processor with a byte-wide data bus and a 16-bit address bus. Every machine cycle lasts three clocks, marked by one-hot phase outputs T1, T2 and T3. The block reads the opcode byte at the program counter into the instruction register, which it drives to an external decoder. During T3 of that cycle it takes the decoder's answer: the instruction length (one, two or three bytes), whether one execute cycle must follow, whether that cycle writes, whether its address comes from an external indirect pointer, and whether the instruction ends in a jump.

Each operand byte is fetched in a machine cycle of its own and shifted into a 16-bit data address register. An immediate byte ends up in the low half of that register. For a three-byte instruction the first operand byte becomes the high half. After the fetch cycles, an optional execute cycle puts either the data address register or the indirect pointer on the address bus and pulses a read or write strobe. The datapath uses the phase, machine-cycle and done outputs to steer its own transfers.

Top module: `byte_fetch_seq`

## Requirements
- R1: While `rst_ni` is low: `pc_o` is 0000h, `phase_o` is 001b (T1), `mcyc_o` is 0, and `mem_rd_o`, `mem_wr_o`, `pc_inc_o` and `instr_done_o` are all low.
- R2: `phase_o` is always one-hot and steps T1 (bit 0), T2 (bit 1), T3 (bit 2), then back to T1, one step per clock.
- R3: In every fetch cycle, `mem_rd_o` is high only during T2 with `mem_addr_o` equal to `pc_o`. The byte is captured at the end of T2. In the opcode cycle (`mcyc_o`=0) that byte appears on `ir_o` during T3.
- R4: `pc_o` increases by one at the end of T2 of each fetch cycle, and `pc_inc_o` is high during that T2. The PC never increments in an execute cycle.
- R5: The length code `dec_len_i` is taken during T3 of the opcode cycle: 2'b10 means two bytes, 2'b11 means three bytes, and any other value means one byte. `mcyc_o` reads 0 for the opcode cycle, 1 and 2 for the operand cycles, and 3 for the execute cycle.
- R6: For a two-byte instruction, `dar_o` equals {00h, second byte} from T3 of its operand cycle onward.
- R7: For a three-byte instruction, `dar_o` equals {second byte, third byte} from T3 of its last operand cycle onward.
- R8: When `dec_xcyc_i` is sampled high, one execute cycle follows the last fetch cycle. In its T2 a strobe is pulsed: `mem_wr_o` if `dec_xwr_i` was high, otherwise `mem_rd_o`. The address is `ind_addr_i` if `dec_xind_i` was high, otherwise `dar_o`. `pc_o` stays unchanged during this cycle.
- R9: `instr_done_o` is high exactly during T3 of an instruction's last machine cycle. An instruction takes (length + execute flag) machine cycles, and the next opcode fetch starts at the following clock.
- R10: When `dec_jump_i` was sampled high, `pc_o` takes the value of `dar_o` at the end of the instruction.
- R11: All decode inputs are ignored except in T3 of the opcode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory address |
| mem_rdata_i | input | 8 | Memory read data |
| mem_rd_o | output | 1 | Read strobe (T2) |
| mem_wr_o | output | 1 | Write strobe (T2 of execute cycle) |
| ir_o | output | 8 | Instruction register, to the decoder |
| dec_len_i | input | 2 | Decoded length code |
| dec_xcyc_i | input | 1 | Decoded: execute cycle needed |
| dec_xwr_i | input | 1 | Decoded: execute cycle writes |
| dec_xind_i | input | 1 | Decoded: execute address from indirect pointer |
| dec_jump_i | input | 1 | Decoded: load PC from data address register at end |
| ind_addr_i | input | 16 | Indirect pointer address |
| pc_o | output | 16 | Program counter |
| dar_o | output | 16 | Data address register |
| pc_inc_o | output | 1 | PC increments at the end of this clock |
| phase_o | output | 3 | One-hot clock phase T1..T3 |
| mcyc_o | output | 2 | Machine cycle kind |
| instr_done_o | output | 1 | Last clock of the instruction |

## Verification
A fixed directed program runs first. It covers a one-byte instruction, an immediate, a three-byte store, an indirect read, a read through the data address register, and jumps by both two-byte and three-byte instructions. Together these separate the length paths from one another, write from read, and indirect from direct addressing. A long random instruction stream follows, with random opcodes and operand bytes and random indirect pointers, and random values on the decode inputs in every clock except T3 of the opcode cycle. A design that samples the decode at any other time produces wrong cycle counts, strobes or PCs.

// File: rtl/byte_fetch_seq_pkg.sv
package byte_fetch_seq_pkg;
  typedef enum logic [1:0] {
    CY_OPC  = 2'd0,
    CY_OPR1 = 2'd1,
    CY_OPR2 = 2'd2,
    CY_EXEC = 2'd3
  } mcyc_e;

  localparam logic [1:0] LEN_TWO   = 2'b10;
  localparam logic [1:0] LEN_THREE = 2'b11;
endpackage

// File: rtl/bfs_phase_ctr.sv
module bfs_phase_ctr #(
  parameter int CYC_CLKS = 3,
  parameter int RD_SLOT  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [CYC_CLKS-1:0] phase_o,
  output logic                strobe_o,
  output logic                last_o
);
  localparam int PH_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == PH_LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < CYC_CLKS; i++) begin : g_phase
    assign phase_o[i] = (cnt_q == PH_W'(i));
  end

  assign strobe_o = phase_o[RD_SLOT];
  assign last_o   = phase_o[CYC_CLKS-1];
endmodule

// File: rtl/bfs_cycle_ctl.sv
module bfs_cycle_ctl
  import byte_fetch_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       last_i,
  input  logic [1:0] dec_len_i,
  input  logic       dec_xcyc_i,
  input  logic       dec_xwr_i,
  input  logic       dec_xind_i,
  input  logic       dec_jump_i,
  output mcyc_e      cyc_o,
  output logic       final_o,
  output logic       xwr_o,
  output logic       xind_o,
  output logic       jump_o
);
  mcyc_e      cyc_q, cyc_nxt;
  logic [1:0] len_q;
  logic       xcyc_q, xwr_q, xind_q, jump_q;
  logic       in_opc, sample;
  logic [1:0] len_e;
  logic       xcyc_e, two_b, three_b;

  assign in_opc = (cyc_q == CY_OPC);
  assign sample = in_opc & last_i;

  // live decode during the opcode cycle, latched copy afterwards
  assign len_e   = in_opc ? dec_len_i  : len_q;
  assign xcyc_e  = in_opc ? dec_xcyc_i : xcyc_q;
  assign two_b   = (len_e == LEN_TWO);
  assign three_b = (len_e == LEN_THREE);

  always_comb begin
    cyc_nxt = CY_OPC;
    unique case (cyc_q)
      CY_OPC:  cyc_nxt = (two_b | three_b) ? CY_OPR1 : (xcyc_e ? CY_EXEC : CY_OPC);
      CY_OPR1: cyc_nxt = three_b ? CY_OPR2 : (xcyc_e ? CY_EXEC : CY_OPC);
      CY_OPR2: cyc_nxt = xcyc_e ? CY_EXEC : CY_OPC;
      CY_EXEC: cyc_nxt = CY_OPC;
      default: cyc_nxt = CY_OPC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CY_OPC;
      len_q  <= '0;
      xcyc_q <= 1'b0;
      xwr_q  <= 1'b0;
      xind_q <= 1'b0;
      jump_q <= 1'b0;
    end else begin
      if (last_i) cyc_q <= cyc_nxt;
      if (sample) begin
        len_q  <= dec_len_i;
        xcyc_q <= dec_xcyc_i;
        xwr_q  <= dec_xwr_i;
        xind_q <= dec_xind_i;
        jump_q <= dec_jump_i;
      end
    end
  end

  assign cyc_o   = cyc_q;
  assign final_o = (cyc_nxt == CY_OPC);
  assign xwr_o   = xwr_q;
  assign xind_o  = xind_q;
  assign jump_o  = in_opc ? dec_jump_i : jump_q;
endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import byte_fetch_seq_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mcyc_e             cyc_i,
  input  logic              strobe_i,
  input  logic              done_i,
  input  logic              jump_i,
  input  logic              xwr_i,
  input  logic              xind_i,
  input  logic [ADDR_W-1:0] ind_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] dar_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              pc_inc_o
);
  logic [ADDR_W-1:0] pc_q, dar_q;
  logic [DATA_W-1:0] ir_q;
  logic              fetch, take;

  assign fetch = (cyc_i != CY_EXEC);
  assign take  = strobe_i & fetch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      dar_q <= '0;
    end else begin
      if (take)                pc_q <= pc_q + 1'b1;
      else if (done_i && jump_i) pc_q <= dar_q;
      if (take) begin
        unique case (cyc_i)
          CY_OPC:  ir_q  <= rdata_i;
          CY_OPR1: dar_q <= {{(ADDR_W-DATA_W){1'b0}}, rdata_i};
          CY_OPR2: dar_q <= {dar_q[ADDR_W-DATA_W-1:0], rdata_i};
          default: ;
        endcase
      end
    end
  end

  assign pc_o     = pc_q;
  assign ir_o     = ir_q;
  assign dar_o    = dar_q;
  assign addr_o   = fetch ? pc_q : (xind_i ? ind_addr_i : dar_q);
  assign rd_o     = strobe_i & (fetch | ~xwr_i);
  assign wr_o     = strobe_i & ~fetch & xwr_i;
  assign pc_inc_o = take;
endmodule

// File: rtl/byte_fetch_seq.sv
module byte_fetch_seq
  import byte_fetch_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CYC_CLKS = 3,
  parameter int RD_SLOT  = 1,
  localparam int ADDR_W  = 2 * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic [DATA_W-1:0]   ir_o,
  input  logic [1:0]          dec_len_i,
  input  logic                dec_xcyc_i,
  input  logic                dec_xwr_i,
  input  logic                dec_xind_i,
  input  logic                dec_jump_i,
  input  logic [ADDR_W-1:0]   ind_addr_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [ADDR_W-1:0]   dar_o,
  output logic                pc_inc_o,
  output logic [CYC_CLKS-1:0] phase_o,
  output logic [1:0]          mcyc_o,
  output logic                instr_done_o
);
  logic  strobe, last, fin, xwr, xind, jump, done;
  mcyc_e cyc;

  bfs_phase_ctr #(.CYC_CLKS(CYC_CLKS), .RD_SLOT(RD_SLOT)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_o  (phase_o),
    .strobe_o (strobe),
    .last_o   (last)
  );

  bfs_cycle_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .last_i     (last),
    .dec_len_i  (dec_len_i),
    .dec_xcyc_i (dec_xcyc_i),
    .dec_xwr_i  (dec_xwr_i),
    .dec_xind_i (dec_xind_i),
    .dec_jump_i (dec_jump_i),
    .cyc_o      (cyc),
    .final_o    (fin),
    .xwr_o      (xwr),
    .xind_o     (xind),
    .jump_o     (jump)
  );

  assign done = last & fin;

  bfs_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_i      (cyc),
    .strobe_i   (strobe),
    .done_i     (done),
    .jump_i     (jump),
    .xwr_i      (xwr),
    .xind_i     (xind),
    .ind_addr_i (ind_addr_i),
    .rdata_i    (mem_rdata_i),
    .pc_o       (pc_o),
    .ir_o       (ir_o),
    .dar_o      (dar_o),
    .addr_o     (mem_addr_o),
    .rd_o       (mem_rd_o),
    .wr_o       (mem_wr_o),
    .pc_inc_o   (pc_inc_o)
  );

  assign mcyc_o       = cyc;
  assign instr_done_o = done;
endmodule

// File: rtl/byte_fetch_seq_chk.sv
module byte_fetch_seq_chk #(
  parameter int DATA_W   = 8,
  parameter int CYC_CLKS = 3,
  parameter int RD_SLOT  = 1,
  localparam int ADDR_W  = 2 * DATA_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mem_rd_o,
  input logic                mem_wr_o,
  input logic [ADDR_W-1:0]   pc_o,
  input logic                pc_inc_o,
  input logic [CYC_CLKS-1:0] phase_o,
  input logic [1:0]          mcyc_o,
  input logic                instr_done_o
);
  a_r2_phase_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);

  a_r2_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[CYC_CLKS-1] |=> phase_o[0]);

  a_r3_rd_in_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> phase_o[RD_SLOT]);

  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> pc_o == ($past(pc_o) + ADDR_W'(1)));

  a_r4_no_inc_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcyc_o == 2'd3) |-> !pc_inc_o);

  a_r8_wr_exec_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mcyc_o == 2'd3) && !mem_rd_o);

  a_r8_exec_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcyc_o == 2'd3) && !phase_o[CYC_CLKS-1] |=> $stable(pc_o));

  a_r9_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_done_o |-> phase_o[CYC_CLKS-1]);

  a_r9_done_then_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_done_o |=> mcyc_o == 2'd0);
endmodule

bind byte_fetch_seq byte_fetch_seq_chk #(
  .DATA_W(DATA_W), .CYC_CLKS(CYC_CLKS), .RD_SLOT(RD_SLOT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .pc_o         (pc_o),
  .pc_inc_o     (pc_inc_o),
  .phase_o      (phase_o),
  .mcyc_o       (mcyc_o),
  .instr_done_o (instr_done_o)
);

// File: tb/byte_fetch_seq_bench.sv
`timescale 1ns/1ps
module byte_fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_rd, mem_wr;
  logic [7:0]  ir;
  logic [1:0]  dec_len;
  logic        dec_xcyc, dec_xwr, dec_xind, dec_jump;
  logic [15:0] ind_addr;
  logic [15:0] pc, dar;
  logic        pc_inc;
  logic [2:0]  phase;
  logic [1:0]  mcyc;
  logic        done;

  logic [7:0]  mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] exp_pc, exp_dar;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  byte_fetch_seq u_byte_fetch_seq (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_o(ir), .dec_len_i(dec_len),
    .dec_xcyc_i(dec_xcyc), .dec_xwr_i(dec_xwr), .dec_xind_i(dec_xind),
    .dec_jump_i(dec_jump), .ind_addr_i(ind_addr), .pc_o(pc), .dar_o(dar),
    .pc_inc_o(pc_inc), .phase_o(phase), .mcyc_o(mcyc), .instr_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // bench decoder: opcode bits [1:0] length, [2] exec, [3] write, [4] indirect, [5] jump
  function automatic int nbytes(input logic [7:0] op);
    return (op[1:0] == 2'b11) ? 3 : (op[1:0] == 2'b10) ? 2 : 1;
  endfunction

  task automatic drive_rand();
    {dec_jump, dec_xind, dec_xwr, dec_xcyc, dec_len} = 6'($urandom);
  endtask

  task automatic nxt();
    drive_rand();
    @(negedge clk);
  endtask

  // entered in T1 of the opcode cycle, leaves in T1 of the next instruction
  task automatic run_instr();
    logic [7:0] op, b;
    int         nb;
    bit         xc;
    ind_addr = 16'($urandom);
    chk(phase == 3'b001, "R2", 32'(phase), 32'h1);
    chk(mcyc == 2'd0, "R9", 32'(mcyc), 32'h0);
    chk(pc == exp_pc, "R10 R11", 32'(pc), 32'(exp_pc));
    nxt();
    chk(phase == 3'b010, "R2", 32'(phase), 32'h2);
    chk(mem_rd && !mem_wr, "R3", 32'({mem_rd, mem_wr}), 32'h2);
    chk(mem_addr == exp_pc, "R3", 32'(mem_addr), 32'(exp_pc));
    chk(pc_inc, "R4", 32'(pc_inc), 32'h1);
    op = mem[exp_pc[7:0]];
    exp_pc = exp_pc + 16'd1;
    nxt();
    chk(phase == 3'b100, "R2", 32'(phase), 32'h4);
    chk(ir == op, "R3", 32'(ir), 32'(op));
    chk(pc == exp_pc, "R4", 32'(pc), 32'(exp_pc));
    chk(!mem_rd && !pc_inc, "R3", 32'({mem_rd, pc_inc}), 32'h0);
    dec_len = op[1:0]; dec_xcyc = op[2]; dec_xwr = op[3];
    dec_xind = op[4];  dec_jump = op[5];
    nb = nbytes(op);
    xc = op[2];
    #1;
    chk(done == (nb == 1 && !xc), "R9", 32'(done), 32'(nb == 1 && !xc));
    @(negedge clk);
    for (int k = 1; k < nb; k++) begin
      chk(mcyc == 2'(k), "R5 R11", 32'(mcyc), 32'(k));
      nxt();
      chk(mem_rd && mem_addr == exp_pc, "R3", 32'(mem_addr), 32'(exp_pc));
      chk(pc_inc, "R4", 32'(pc_inc), 32'h1);
      b = mem[exp_pc[7:0]];
      exp_dar = (k == 1) ? {8'h00, b} : {exp_dar[7:0], b};
      exp_pc = exp_pc + 16'd1;
      nxt();
      chk(dar == exp_dar, (nb == 2) ? "R6" : "R7", 32'(dar), 32'(exp_dar));
      chk(done == (k == nb - 1 && !xc), "R9", 32'(done), 32'(k == nb - 1 && !xc));
      nxt();
    end
    if (xc) begin
      chk(mcyc == 2'd3, "R8 R11", 32'(mcyc), 32'h3);
      nxt();
      chk(mem_addr == (op[4] ? ind_addr : exp_dar), "R8",
          32'(mem_addr), 32'(op[4] ? ind_addr : exp_dar));
      chk(mem_wr == op[3] && mem_rd == !op[3], "R8",
          32'({mem_rd, mem_wr}), 32'({!op[3], op[3]}));
      chk(!pc_inc, "R4", 32'(pc_inc), 32'h0);
      nxt();
      chk(pc == exp_pc, "R8", 32'(pc), 32'(exp_pc));
      chk(done, "R9", 32'(done), 32'h1);
      nxt();
    end
    if (op[5]) exp_pc = exp_dar;
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    // directed program
    mem[8'h00] = 8'h01;                                     // one byte
    mem[8'h01] = 8'h02; mem[8'h02] = 8'hA5;                 // immediate
    mem[8'h03] = 8'h0F; mem[8'h04] = 8'h12; mem[8'h05] = 8'h34; // store to DAR
    mem[8'h06] = 8'h17; mem[8'h07] = 8'hC3; mem[8'h08] = 8'h5A; // indirect read
    mem[8'h09] = 8'h07; mem[8'h0A] = 8'hAB; mem[8'h0B] = 8'hCD; // read at DAR
    mem[8'h0C] = 8'h2B; mem[8'h0D] = 8'h00; mem[8'h0E] = 8'h40; // three-byte jump
    mem[8'h40] = 8'h04;                                     // one byte + exec read
    mem[8'h41] = 8'h22; mem[8'h42] = 8'h80;                 // two-byte jump
    rst_ni = 1'b0;
    ind_addr = 16'h0;
    drive_rand();
    exp_pc = 16'h0000;
    exp_dar = 16'h0000;
    repeat (3) @(negedge clk);
    chk(pc == 16'h0 && phase == 3'b001 && mcyc == 2'd0, "R1",
        32'({pc, phase, mcyc}), 32'h4);
    chk(!mem_rd && !mem_wr && !pc_inc && !done, "R1",
        32'({mem_rd, mem_wr, pc_inc, done}), 32'h0);
    rst_ni = 1'b1;
    for (int n = 0; n < 3000; n++) run_instr();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected instruction completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule